// File: doc/BRIEF.md
# Pending Request Count Tracker

This block sits on the central arbiter of a switch whose ingress adapters are far from the arbiter. Adapters do not report how full their virtual output queues are. Each time a cell is queued, an adapter sends one request message, and each grant the arbiter returns removes one cell's worth of credit. The tracker keeps one saturating counter for every (input, output) queue. It raises the request bit for a queue while that queue's counter is nonzero, and the matcher reads these bits as its request bitmap.

The round trip between adapter and arbiter is long, and control messages can be lost. For that reason an adapter sends a periodic census for a queue. A census carries the adapter's count, net of the grants it has already received. The tracker keeps a short history of the grants it issued. When a census arrives, it subtracts the grants from that history that are still on their way to the adapter, and overwrites the counter with the result. In this way a lost request or a lost grant is repaired without stopping traffic.

Top module: `pct_tracker`

## Requirements
- R1: After a synchronous active-low reset, every counter is zero, `req_map` is all zeros and `underflow_err` is 0.
- R2: A request for queue (i, o) increments that queue's counter by one. The queue's bitmap position is i*NUM_OUT + o.
- R3: A counter saturates at 2^CNT_W-1 (15 by default). Further requests leave it at that value, so exactly 2^CNT_W-1 grants drain it.
- R4: A grant for a queue with a nonzero counter decrements that counter by one.
- R5: A request and a grant to the same queue in the same cycle leave its counter unchanged.
- R6: A grant to a queue whose counter is zero, with no request to that queue in the same cycle, leaves the counter at zero. It also sets `underflow_err`, which stays 1 until reset.
- R7: A census for a queue loads the counter with `cen_count` minus the grants to that queue in the current cycle and the previous HIST cycles (6 by default), clamped at zero. A request to that queue in the same cycle then adds one, with saturation. A grant older than HIST cycles is not subtracted. A grant in the census cycle counts only as history and sets no error.
- R8: `req_map` bit k is 1 exactly when counter k is nonzero. It reflects an update from the cycle after the event that caused it.
- R9: Requests, grants and census messages change only the counter of the queue they address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request increment this cycle |
| req_in | input | $clog2(NUM_IN) | Input port of the request |
| req_out | input | $clog2(NUM_OUT) | Output port of the request |
| gnt_valid | input | 1 | Grant issued by the matcher this cycle |
| gnt_in | input | $clog2(NUM_IN) | Input port of the grant |
| gnt_out | input | $clog2(NUM_OUT) | Output port of the grant |
| cen_valid | input | 1 | Census correction this cycle |
| cen_in | input | $clog2(NUM_IN) | Input port of the census |
| cen_out | input | $clog2(NUM_OUT) | Output port of the census |
| cen_count | input | CNT_W | Adapter count carried by the census |
| req_map | output | NUM_IN*NUM_OUT | Nonzero-count bitmap, bit i*NUM_OUT+o |
| underflow_err | output | 1 | Sticky grant-underflow flag |

## Verification
The hardest case to reach is a census whose correction depends on grant history. The loaded value depends on how many grants to that queue fall within the last HIST cycles, and only the bitmap shows the counter. The stimulus places grants a known number of cycles before a census, one cycle inside and one cycle outside the window. It then counts the grants needed to clear the bitmap bit, which recovers the exact loaded value. A census that coincides with a grant and with a request, and a census that clamps at zero, are driven in the vector table.

// File: rtl/pct_pkg.sv
// Package: shared types for the pending request count tracker.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pct_pkg;
    // Action taken by one counter cell in a given cycle.
    typedef enum logic [1:0] {
        CELL_HOLD = 2'd0,
        CELL_INC  = 2'd1,
        CELL_DEC  = 2'd2,
        CELL_LOAD = 2'd3
    } cell_act_e;
endpackage

// File: rtl/pct_count_cell.sv
// Module: one saturating pending-request counter.
// Does: +1 on inc, -1 on dec, no change on both, census load with optional
// same-cycle increment; floors at zero and flags a floor hit by a grant.
// Assumes: load_val is already corrected for in-flight grants by the parent.
module pct_count_cell
    import pct_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             nz,
    output logic             uflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cell_act_e act;

    // Choose this cycle's action; a census overrides grant and request.
    always_comb begin
        if (load)             act = CELL_LOAD;
        else if (inc && !dec) act = CELL_INC;
        else if (dec && !inc) act = CELL_DEC;
        else                  act = CELL_HOLD;
    end

    // Update the counter with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (act)
                CELL_INC:  if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
                CELL_DEC:  if (cnt != '0)      cnt <= cnt - CNT_ONE;
                CELL_LOAD: cnt <= (inc && load_val != CNT_MAX) ? load_val + CNT_ONE : load_val;
                default:   cnt <= cnt;
            endcase
        end
    end

    // Report nonzero state and a grant that found nothing pending.
    always_comb begin
        nz    = (cnt != '0);
        uflow = (act == CELL_DEC) && (cnt == '0);
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && inc && !dec && !load) |=> (cnt == CNT_MAX));
    assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dec && !inc && !load) |=> (cnt == '0));
    assert_net_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && !load) |=> $stable(cnt));
    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && !load && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_ONE));
endmodule

// File: rtl/pct_grant_history.sv
// Module: shift register of recent grants.
// Does: counts the grants to a probed queue in the current cycle plus the
// previous HIST cycles, so a census can remove grants still in flight.
// Assumes: HIST + 1 fits in HW bits (guaranteed by the localparam).
module pct_grant_history #(
    parameter int QW   = 4,
    parameter int HIST = 6,
    localparam int HW  = $clog2(HIST + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_valid,
    input  logic [QW-1:0] gnt_q,
    input  logic [QW-1:0] probe_q,
    output logic [HW-1:0] hits
);
    logic          hv [HIST];
    logic [QW-1:0] hq [HIST];

    genvar g;
    generate
        for (g = 0; g < HIST; g++) begin : g_stage
            // Shift one grant record per cycle; stage 0 takes the new grant.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hv[g] <= 1'b0;
                    hq[g] <= '0;
                end else if (g == 0) begin
                    hv[g] <= gnt_valid;
                    hq[g] <= gnt_q;
                end else begin
                    hv[g] <= hv[(g == 0) ? 0 : g - 1];
                    hq[g] <= hq[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Count matching grants, including the one issued this cycle.
    always_comb begin
        hits = (gnt_valid && gnt_q == probe_q) ? HW'(1) : '0;
        for (int i = 0; i < HIST; i++) begin
            if (hv[i] && hq[i] == probe_q) hits = hits + HW'(1);
        end
    end
endmodule

// File: rtl/pct_tracker.sv
// Module: top of the pending request count tracker.
// Does: one counter per (input, output) queue, nonzero bitmap for the matcher,
// census correction against grant history, sticky underflow flag.
// Assumes: NUM_IN, NUM_OUT >= 2; HIST < 2**CNT_W; one message of each kind per cycle.
module pct_tracker #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    parameter int CNT_W   = 4,
    parameter int HIST    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [$clog2(NUM_IN)-1:0]    req_in,
    input  logic [$clog2(NUM_OUT)-1:0]   req_out,
    input  logic                         gnt_valid,
    input  logic [$clog2(NUM_IN)-1:0]    gnt_in,
    input  logic [$clog2(NUM_OUT)-1:0]   gnt_out,
    input  logic                         cen_valid,
    input  logic [$clog2(NUM_IN)-1:0]    cen_in,
    input  logic [$clog2(NUM_OUT)-1:0]   cen_out,
    input  logic [CNT_W-1:0]             cen_count,
    output logic [NUM_IN*NUM_OUT-1:0]    req_map,
    output logic                         underflow_err
);
    localparam int NQ = NUM_IN * NUM_OUT;
    localparam int QW = $clog2(NQ);
    localparam int HW = $clog2(HIST + 2);

    logic [QW-1:0]    req_q, gnt_q, cen_q;
    logic [HW-1:0]    hits;
    logic [CNT_W:0]   cen_diff;
    logic [CNT_W-1:0] cen_corr;
    logic [NQ-1:0]    uflow_vec;

    // Flatten (input, output) pairs into queue indices.
    always_comb begin
        req_q = QW'(req_in) * QW'(NUM_OUT) + QW'(req_out);
        gnt_q = QW'(gnt_in) * QW'(NUM_OUT) + QW'(gnt_out);
        cen_q = QW'(cen_in) * QW'(NUM_OUT) + QW'(cen_out);
    end

    pct_grant_history #(.QW(QW), .HIST(HIST)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt_valid(gnt_valid),
        .gnt_q    (gnt_q),
        .probe_q  (cen_q),
        .hits     (hits)
    );

    // Remove in-flight grants from the census value, clamping at zero.
    always_comb begin
        cen_diff = {1'b0, cen_count} - (CNT_W + 1)'(hits);
        cen_corr = cen_diff[CNT_W] ? '0 : cen_diff[CNT_W-1:0];
    end

    genvar k;
    generate
        for (k = 0; k < NQ; k++) begin : g_q
            logic [CNT_W-1:0] cnt;
            pct_count_cell #(.CNT_W(CNT_W)) cell_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (req_valid && req_q == QW'(k)),
                .dec     (gnt_valid && gnt_q == QW'(k)),
                .load    (cen_valid && cen_q == QW'(k)),
                .load_val(cen_corr),
                .cnt     (cnt),
                .nz      (req_map[k]),
                .uflow   (uflow_vec[k])
            );
        end
    endgenerate

    // Hold the underflow flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) underflow_err <= 1'b0;
        else        underflow_err <= underflow_err | (|uflow_vec);
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    assert_census_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_valid && !(req_valid && req_q == cen_q))
        |=> (req_map[$past(cen_q)] == ($past(cen_corr) != '0)));
    assert_req_sets_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(gnt_valid && gnt_q == req_q) && !cen_valid) |=> req_map[$past(req_q)]);
endmodule

// File: tb/pct_tracker_tb_top.sv
// Bench: vector table walked by one loop, then directed reset, saturation
// and census-window tests. 125 MHz clock.
module pct_tracker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, gnt_valid = 0, cen_valid = 0;
    logic [1:0] req_in = 0, req_out = 0, gnt_in = 0, gnt_out = 0, cen_in = 0, cen_out = 0;
    logic [3:0] cen_count = 0;
    logic [15:0] req_map;
    logic underflow_err;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pct_tracker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_in(req_in), .req_out(req_out),
        .gnt_valid(gnt_valid), .gnt_in(gnt_in), .gnt_out(gnt_out),
        .cen_valid(cen_valid), .cen_in(cen_in), .cen_out(cen_out), .cen_count(cen_count),
        .req_map(req_map), .underflow_err(underflow_err)
    );

    // {rv,ri,ro, gv,gi,go, cv,ci,co,cc, exp_map, exp_err}
    localparam int NV = 17;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0001, 1'b0},
        {1'b1,2'd1,2'd2, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0041, 1'b0},
        {1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0041, 1'b0},
        {1'b0,2'd0,2'd0, 1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0041, 1'b0},
        {1'b1,2'd1,2'd2, 1'b1,2'd1,2'd2, 1'b0,2'd0,2'd0,4'd0, 16'h0041, 1'b0},
        {1'b0,2'd0,2'd0, 1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0040, 1'b0},
        {1'b0,2'd0,2'd0, 1'b1,2'd3,2'd3, 1'b0,2'd0,2'd0,4'd0, 16'h0040, 1'b1},
        {1'b1,2'd3,2'd3, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h8040, 1'b1},
        {1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0, 1'b1,2'd0,2'd0,4'd5, 16'h8041, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd1,2'd2, 1'b0,2'd0,2'd0,4'd0, 16'h8001, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd1,2'd2, 1'b1,2'd1,2'd2,4'd1, 16'h8001, 1'b1},
        {1'b1,2'd3,2'd3, 1'b0,2'd0,2'd0, 1'b1,2'd3,2'd3,4'd2, 16'h8001, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd3,2'd3, 1'b0,2'd0,2'd0,4'd0, 16'h8001, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd3,2'd3, 1'b0,2'd0,2'd0,4'd0, 16'h0001, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0001, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0001, 1'b1},
        {1'b0,2'd0,2'd0, 1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0,4'd0, 16'h0000, 1'b1}
    };
    // Requirement exercised by each table row.
    localparam string VTAG [NV] = '{"R2","R2/R9","R2","R4","R5","R4/R8","R6","R6/R2",
        "R7","R4","R7","R7","R4","R4/R8","R7","R7","R7"};

    task automatic chk(input string tag, input logic [15:0] exp_map, input logic exp_err);
        n_chk++;
        if (req_map !== exp_map || underflow_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: map=%h err=%b expected map=%h err=%b",
                     tag, req_map, underflow_err, exp_map, exp_err);
        end
    endtask

    task automatic idle();
        req_valid = 0; gnt_valid = 0; cen_valid = 0;
    endtask

    // Drive one cycle of stimulus from a negedge and return at the next one.
    task automatic cyc(input logic rv, input int q_r, input logic gv, input int q_g,
                       input logic cv, input int q_c, input int cc);
        req_valid = rv; req_in = 2'(q_r / 4); req_out = 2'(q_r % 4);
        gnt_valid = gv; gnt_in = 2'(q_g / 4); gnt_out = 2'(q_g % 4);
        cen_valid = cv; cen_in = 2'(q_c / 4); cen_out = 2'(q_c % 4);
        cen_count = 4'(cc);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        logic [35:0] v;
        do_reset();
        chk("R1 reset state", 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            req_valid = v[35]; req_in = v[34:33]; req_out = v[32:31];
            gnt_valid = v[30]; gnt_in = v[29:28]; gnt_out = v[27:26];
            cen_valid = v[25]; cen_in = v[24:23]; cen_out = v[22:21];
            cen_count = v[20:17];
            @(negedge clk);
            idle();
            chk($sformatf("%s vector %0d", VTAG[i], i), v[16:1], v[0]);
        end

        // R1: reset clears sticky error and bitmap
        do_reset();
        chk("R1 reset after error", 16'h0000, 1'b0);

        // R3: saturate queue 5, then drain exactly 15 grants
        for (int i = 0; i < 20; i++) cyc(1, 5, 0, 0, 0, 0, 0);
        chk("R3 saturated count nonzero", 16'h0020, 1'b0);
        for (int i = 0; i < 14; i++) cyc(0, 0, 1, 5, 0, 0, 0);
        chk("R3 one left after 14 grants", 16'h0020, 1'b0);
        cyc(0, 0, 1, 5, 0, 0, 0);
        chk("R3 drained by 15th grant", 16'h0000, 1'b0);

        // R7: grant HIST+1 cycles before census is not subtracted
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        repeat (6) @(negedge clk);
        cyc(0, 0, 0, 0, 1, 1, 2);
        chk("R7 outside window loads 2", 16'h0002, 1'b0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        chk("R7 outside window one left", 16'h0002, 1'b0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        chk("R7 outside window drained", 16'h0000, 1'b0);

        // R7: grant HIST cycles before census is subtracted
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        repeat (5) @(negedge clk);
        cyc(0, 0, 0, 0, 1, 1, 2);
        chk("R7 inside window loads 1", 16'h0002, 1'b0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        chk("R7 inside window drained", 16'h0000, 1'b0);

        // R9: census to one queue leaves another untouched
        cyc(1, 10, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 3, 0);
        chk("R9 other queue kept", 16'h0400, 1'b0);

        finish_run();
    end
endmodule